// File: doc/BRIEF.md
# PAL Vertical Sync and Field Timing Generator

This block produces the vertical timing of a 625-line interlaced PAL raster. A free-running line counter advances on each horizontal-sync strobe and can be forced back to line 1 by a frame-alignment pulse. Around two reference lines, one per field, it places the rising and falling edges of a vertical sync pulse, the edge of a field indicator, and a V flag meant for embedded timing codes.

The start of vsync is a signed offset from the field's reference line. It can be moved earlier or later by up to 31 lines, pushed one more line later separately for each field, or pulled in by half a line for each field. In that last case the pulse starts on the mid-line strobe of the line before. The end of vsync and the field edge are unsigned offsets after the reference line. All timing settings are sampled only when the counter enters line 1, so a frame is always laid out from one consistent set of values.

Top module: `pal_vsync_gen`

## Requirements
- R1: After reset, `vs_out` and `v_flag` are 0 and `field_out` is 1. The internal line count rests at 625, so the first horizontal-sync strobe enters line 1.
- R2: Each `hs_strobe` advances the line count, wrapping from 625 to 1. An `hs_strobe` with `frame_sync` high enters line 1 at once.
- R3: With `vs_begin_cfg[5]` = 1, vsync rises on the strobe that enters line REF − `vs_begin_cfg[4:0]`, wrapped into 1..625. REF is 1 for the odd field and 314 for the even field.
- R4: With `vs_begin_cfg[5]` = 0, vsync rises on entry to line REF + `vs_begin_cfg[4:0]`.
- R5: `vs_begin_cfg[7]` = 1 moves the odd-field rise one line later and leaves the even field alone.
- R6: `vs_begin_cfg[6]` = 1 moves the even-field rise one line later and leaves the odd field alone.
- R7: With `half_adv_odd` (or `half_adv_even`) set, that field's rise happens on the `half_strobe` of the line before the computed begin line, not on the horizontal strobe.
- R8: Vsync falls on the `hs_strobe` that enters line REF + `vs_end_off`. If a rise and a fall fall on the same strobe, the rise wins.
- R9: `v_flag` changes only on `hs_strobe`, and it then equals the vsync level after that strobe.
- R10: `field_out` goes to 0 on entry to line 1 + `fld_tog_off` and to 1 on entry to line 314 + `fld_tog_off`, and changes at no other time.
- R11: The timing inputs are captured on the strobe that enters line 1 and take effect from that strobe on. A change made in the middle of a frame has no effect before then.
- R12: The end line of a pulse is fixed when the pulse rises. A pulse that spans the frame boundary ends where it was set to end, even if the captured end offset changes meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hs_strobe | input | 1 | One-cycle pulse at the start of each line |
| half_strobe | input | 1 | One-cycle pulse at the middle of each line |
| frame_sync | input | 1 | With `hs_strobe`, forces entry to line 1 |
| vs_begin_cfg | input | 8 | [7] odd one-line delay, [6] even one-line delay, [5] advance sign, [4:0] begin offset |
| vs_end_off | input | 5 | Lines from the reference line to the vsync end |
| fld_tog_off | input | 5 | Lines from the reference line to the field edge |
| half_adv_odd | input | 1 | Half-line advance of the odd-field vsync start |
| half_adv_even | input | 1 | Half-line advance of the even-field vsync start |
| vs_out | output | 1 | Vertical sync output |
| v_flag | output | 1 | Line-aligned V flag for embedded timing codes |
| field_out | output | 1 | Field indicator, 0 in the odd field |

## Verification
The end of vsync and the field edge can land on the same horizontal strobe. Setting `vs_end_off` equal to `fld_tog_off` provokes this: at line 9 of the odd field, `vs_out` must fall and `field_out` must drop to 0 in the same sampled cycle, and neither event may mask the other. A second collision is a rise and the fall of an older pulse on one strobe, which happens when new settings arrive at the frame boundary while the previous odd pulse is still high. There the rise must win and the end line must be latched again.

// File: rtl/pal_vs_pkg.sv
package pal_vs_pkg;

  localparam int OFF_W = 5;

  typedef struct packed {
    logic             dly_odd;
    logic             dly_even;
    logic             adv_sign;
    logic [OFF_W-1:0] off;
  } vs_begin_t;

  typedef struct packed {
    vs_begin_t        beg;
    logic [OFF_W-1:0] end_off;
    logic [OFF_W-1:0] tog_off;
    logic             half_odd;
    logic             half_even;
  } vs_cfg_t;

  localparam vs_begin_t BEGIN_RST = '{dly_odd: 1'b0, dly_even: 1'b1,
                                      adv_sign: 1'b1, off: 5'b00101};
  localparam logic [OFF_W-1:0] END_RST = 5'd4;
  localparam logic [OFF_W-1:0] TOG_RST = 5'd6;

  // bring a line number that drifted across the frame edge back into 1..lines
  function automatic int wrap_line(input int x, input int lines);
    if (x < 1)
      return x + lines;
    else if (x > lines)
      return x - lines;
    else
      return x;
  endfunction

  // first line of vsync for a field whose vertical interval is anchored at ref_ln
  function automatic int begin_line(input int ref_ln, input logic sign,
                                    input logic [OFF_W-1:0] off,
                                    input logic dly, input int lines);
    int ofs;
    ofs = sign ? -int'(off) : int'(off);
    return wrap_line(ref_ln + ofs + int'(dly), lines);
  endfunction

endpackage

// File: rtl/pal_line_tracker.sv
module pal_line_tracker #(
  parameter int LINES  = 625,
  parameter int LINE_W = $clog2(LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_strobe,
  input  logic              frame_sync,
  output logic [LINE_W-1:0] line_q,
  output logic [LINE_W-1:0] line_nxt,
  output logic              frame_load
);

  localparam logic [LINE_W-1:0] LAST  = LINE_W'(LINES);
  localparam logic [LINE_W-1:0] FIRST = LINE_W'(1);

  always_comb begin
    line_nxt = line_q;
    if (hs_strobe) begin
      if (frame_sync || line_q == LAST)
        line_nxt = FIRST;
      else
        line_nxt = line_q + FIRST;
    end
    frame_load = hs_strobe && (line_nxt == FIRST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      line_q <= LAST;
    else if (hs_strobe)
      line_q <= line_nxt;
  end

endmodule

// File: rtl/pal_cfg_shadow.sv
module pal_cfg_shadow
  import pal_vs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  vs_cfg_t cfg_in,
  output vs_cfg_t cfg_eff
);

  vs_cfg_t cfg_q;

  // the values captured at the frame edge already govern that strobe
  always_comb begin
    cfg_eff = load ? cfg_in : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.beg       <= BEGIN_RST;
      cfg_q.end_off   <= END_RST;
      cfg_q.tog_off   <= TOG_RST;
      cfg_q.half_odd  <= 1'b0;
      cfg_q.half_even <= 1'b0;
    end else if (load) begin
      cfg_q <= cfg_in;
    end
  end

endmodule

// File: rtl/pal_vs_edge_ctrl.sv
module pal_vs_edge_ctrl
  import pal_vs_pkg::*;
#(
  parameter int LINES    = 625,
  parameter int LINE_W   = $clog2(LINES + 1),
  parameter int REF_ODD  = 1,
  parameter int REF_EVEN = 314
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_strobe,
  input  logic              half_strobe,
  input  logic [LINE_W-1:0] line_q,
  input  logic [LINE_W-1:0] line_nxt,
  input  vs_begin_t         beg,
  input  logic [OFF_W-1:0]  end_off,
  input  logic              half_odd,
  input  logic              half_even,
  output logic              vs_out,
  output logic              v_flag
);

  localparam int NFLD = 2;
  localparam logic [LINE_W-1:0] LAST  = LINE_W'(LINES);
  localparam logic [LINE_W-1:0] FIRST = LINE_W'(1);

  logic [LINE_W-1:0] line_after;
  logic [NFLD-1:0]   rise_hs;
  logic [NFLD-1:0]   rise_half;
  logic [LINE_W-1:0] end_ln   [NFLD];
  logic [LINE_W-1:0] begin_ln [NFLD];

  logic              vs_q, vs_nxt;
  logic              v_q, v_nxt;
  logic [LINE_W-1:0] end_q, end_nxt;
  logic              rise_any, fall;

  // line that follows the current one, for a rise on the mid-line strobe
  assign line_after = (line_q == LAST) ? FIRST : line_q + FIRST;

  for (genvar f = 0; f < NFLD; f++) begin : g_fld
    localparam int REF_LN = (f == 0) ? REF_ODD : REF_EVEN;
    logic dly;
    logic hadv;
    assign dly  = (f == 0) ? beg.dly_odd : beg.dly_even;
    assign hadv = (f == 0) ? half_odd    : half_even;
    assign begin_ln[f] = LINE_W'(begin_line(REF_LN, beg.adv_sign, beg.off, dly, LINES));
    assign end_ln[f]   = LINE_W'(wrap_line(REF_LN + int'(end_off), LINES));
    assign rise_hs[f]   = hs_strobe && !hadv && (line_nxt == begin_ln[f]);
    assign rise_half[f] = half_strobe && hadv && (line_after == begin_ln[f]);
  end

  always_comb begin
    rise_any = |{rise_hs, rise_half};
    fall     = vs_q && hs_strobe && (line_nxt == end_q) && !rise_any;
    vs_nxt   = vs_q;
    end_nxt  = end_q;
    if (rise_any) begin
      vs_nxt  = 1'b1;
      end_nxt = (rise_hs[0] || rise_half[0]) ? end_ln[0] : end_ln[1];
    end else if (fall) begin
      vs_nxt = 1'b0;
    end
    v_nxt = hs_strobe ? vs_nxt : v_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q  <= 1'b0;
      v_q   <= 1'b0;
      end_q <= LAST;
    end else begin
      if (rise_any || fall)
        vs_q <= vs_nxt;
      if (rise_any)
        end_q <= end_nxt;
      if (hs_strobe)
        v_q <= v_nxt;
    end
  end

  assign vs_out = vs_q;
  assign v_flag = v_q;

endmodule

// File: rtl/pal_field_ctrl.sv
module pal_field_ctrl
  import pal_vs_pkg::*;
#(
  parameter int LINES    = 625,
  parameter int LINE_W   = $clog2(LINES + 1),
  parameter int REF_ODD  = 1,
  parameter int REF_EVEN = 314
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_strobe,
  input  logic [LINE_W-1:0] line_nxt,
  input  logic [OFF_W-1:0]  tog_off,
  output logic              field_out
);

  localparam int NFLD = 2;

  logic [LINE_W-1:0] tog_ln [NFLD];
  logic [NFLD-1:0]   hit;
  logic              fld_q, fld_nxt;

  for (genvar f = 0; f < NFLD; f++) begin : g_tog
    localparam int REF_LN = (f == 0) ? REF_ODD : REF_EVEN;
    assign tog_ln[f] = LINE_W'(wrap_line(REF_LN + int'(tog_off), LINES));
    assign hit[f]    = hs_strobe && (line_nxt == tog_ln[f]);
  end

  always_comb begin
    fld_nxt = fld_q;
    if (hit[0])
      fld_nxt = 1'b0;
    else if (hit[1])
      fld_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fld_q <= 1'b1;
    else if (|hit)
      fld_q <= fld_nxt;
  end

  assign field_out = fld_q;

endmodule

// File: rtl/pal_vsync_gen.sv
module pal_vsync_gen
  import pal_vs_pkg::*;
#(
  parameter int LINES    = 625,
  parameter int REF_ODD  = 1,
  parameter int REF_EVEN = 314
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_strobe,
  input  logic             half_strobe,
  input  logic             frame_sync,
  input  logic [OFF_W+2:0] vs_begin_cfg,
  input  logic [OFF_W-1:0] vs_end_off,
  input  logic [OFF_W-1:0] fld_tog_off,
  input  logic             half_adv_odd,
  input  logic             half_adv_even,
  output logic             vs_out,
  output logic             v_flag,
  output logic             field_out
);

  localparam int LINE_W = $clog2(LINES + 1);

  logic [LINE_W-1:0] line_cur;
  logic [LINE_W-1:0] line_nxt;
  logic              frame_load;
  vs_cfg_t           cfg_in;
  vs_cfg_t           cfg_eff;

  always_comb begin
    cfg_in.beg       = vs_begin_t'(vs_begin_cfg);
    cfg_in.end_off   = vs_end_off;
    cfg_in.tog_off   = fld_tog_off;
    cfg_in.half_odd  = half_adv_odd;
    cfg_in.half_even = half_adv_even;
  end

  pal_line_tracker #(.LINES(LINES), .LINE_W(LINE_W)) u_lines (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_strobe  (hs_strobe),
    .frame_sync (frame_sync),
    .line_q     (line_cur),
    .line_nxt   (line_nxt),
    .frame_load (frame_load)
  );

  pal_cfg_shadow u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (frame_load),
    .cfg_in  (cfg_in),
    .cfg_eff (cfg_eff)
  );

  pal_vs_edge_ctrl #(.LINES(LINES), .LINE_W(LINE_W),
                     .REF_ODD(REF_ODD), .REF_EVEN(REF_EVEN)) u_vs (
    .clk         (clk),
    .rst_n       (rst_n),
    .hs_strobe   (hs_strobe),
    .half_strobe (half_strobe),
    .line_q      (line_cur),
    .line_nxt    (line_nxt),
    .beg         (cfg_eff.beg),
    .end_off     (cfg_eff.end_off),
    .half_odd    (cfg_eff.half_odd),
    .half_even   (cfg_eff.half_even),
    .vs_out      (vs_out),
    .v_flag      (v_flag)
  );

  pal_field_ctrl #(.LINES(LINES), .LINE_W(LINE_W),
                   .REF_ODD(REF_ODD), .REF_EVEN(REF_EVEN)) u_fld (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_strobe (hs_strobe),
    .line_nxt  (line_nxt),
    .tog_off   (cfg_eff.tog_off),
    .field_out (field_out)
  );

endmodule

// File: rtl/pal_vsync_gen_chk.sv
module pal_vsync_gen_chk #(
  parameter int LINES = 625
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         hs_strobe,
  input logic                         half_strobe,
  input logic                         frame_sync,
  input logic                         vs_out,
  input logic                         v_flag,
  input logic                         field_out,
  input logic [$clog2(LINES+1)-1:0]   line_cur
);

  p_line_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cur >= 1) && (int'(line_cur) <= LINES));

  p_fsync_line1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hs_strobe && frame_sync) |-> (line_cur == 1));

  p_vs_rise_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs_out) |-> $past(hs_strobe || half_strobe));

  p_vs_fall_hs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vs_out) |-> $past(hs_strobe));

  p_v_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hs_strobe) |-> $stable(v_flag));

  p_v_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hs_strobe) |-> (v_flag == vs_out));

  p_field_on_hs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field_out) |-> $past(hs_strobe));

endmodule

bind pal_vsync_gen pal_vsync_gen_chk #(.LINES(LINES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hs_strobe   (hs_strobe),
  .half_strobe (half_strobe),
  .frame_sync  (frame_sync),
  .vs_out      (vs_out),
  .v_flag      (v_flag),
  .field_out   (field_out),
  .line_cur    (line_cur)
);

// File: tb/pal_vsync_gen_tb.sv
module pal_vsync_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NLINES     = 625;
  localparam int MAX_EV     = 64;

  // event kinds
  localparam int K_RISE_HS   = 1;
  localparam int K_RISE_HALF = 2;
  localparam int K_FALL      = 3;
  localparam int K_V_RISE    = 4;
  localparam int K_V_FALL    = 5;
  localparam int K_FLD0      = 6;
  localparam int K_FLD1      = 7;
  localparam int K_V_HALF    = 8;
  localparam int K_FALL_HALF = 9;
  localparam int K_FLD_HALF  = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic hs_strobe, half_strobe, frame_sync;
  logic [7:0] vs_begin_cfg;
  logic [4:0] vs_end_off, fld_tog_off;
  logic half_adv_odd, half_adv_even;
  logic vs_out, v_flag, field_out;

  int checks = 0;
  int failures = 0;
  int bl;
  int ev_n;
  int ev_kind [MAX_EV];
  int ev_line [MAX_EV];
  logic pv, pvf, pf;

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_vsync_gen u_dut (
    .clk(clk), .rst_n(rst_n), .hs_strobe(hs_strobe), .half_strobe(half_strobe),
    .frame_sync(frame_sync), .vs_begin_cfg(vs_begin_cfg), .vs_end_off(vs_end_off),
    .fld_tog_off(fld_tog_off), .half_adv_odd(half_adv_odd),
    .half_adv_even(half_adv_even), .vs_out(vs_out), .v_flag(v_flag),
    .field_out(field_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic add_ev(input int k);
    if (ev_n < MAX_EV) begin
      ev_kind[ev_n] = k;
      ev_line[ev_n] = bl;
      ev_n++;
    end
  endtask

  task automatic rec(input bit half);
    if (vs_out !== pv)
      add_ev(vs_out ? (half ? K_RISE_HALF : K_RISE_HS) : (half ? K_FALL_HALF : K_FALL));
    if (v_flag !== pvf)
      add_ev(half ? K_V_HALF : (v_flag ? K_V_RISE : K_V_FALL));
    if (field_out !== pf)
      add_ev(half ? K_FLD_HALF : (field_out ? K_FLD1 : K_FLD0));
    pv = vs_out; pvf = v_flag; pf = field_out;
  endtask

  function automatic int find_ev(input int k, input int minl);
    for (int i = 0; i < ev_n; i++)
      if (ev_kind[i] == k && ev_line[i] >= minl)
        return ev_line[i];
    return -1;
  endfunction

  task automatic clear_ev();
    ev_n = 0;
  endtask

  task automatic step_line(input bit fs);
    @(negedge clk);
    hs_strobe = 1'b1; frame_sync = fs;
    @(negedge clk);
    hs_strobe = 1'b0; frame_sync = 1'b0;
    bl = fs ? 1 : ((bl == NLINES) ? 1 : bl + 1);
    rec(1'b0);
    @(negedge clk);
    @(negedge clk);
    half_strobe = 1'b1;
    @(negedge clk);
    half_strobe = 1'b0;
    rec(1'b1);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_lines(input int n);
    for (int i = 0; i < n; i++) step_line(1'b0);
  endtask

  task automatic set_cfg(input logic [7:0] b, input logic [4:0] e, input logic [4:0] t,
                         input logic ho, input logic he);
    vs_begin_cfg = b; vs_end_off = e; fld_tog_off = t;
    half_adv_odd = ho; half_adv_even = he;
  endtask

  task automatic t_reset();
    chk("R1 vs_out after reset", int'(vs_out), 0);
    chk("R1 v_flag after reset", int'(v_flag), 0);
    chk("R1 field_out after reset", int'(field_out), 1);
  endtask

  // defaults: advance 5, even delayed one line, end 4, field edge 6
  task automatic t_defaults();
    set_cfg(8'h65, 5'd4, 5'd6, 1'b0, 1'b0);
    clear_ev();
    run_lines(NLINES);
    chk("R3 R6 even rise at 314-5+1", find_ev(K_RISE_HS, 300), 310);
    chk("R8 even fall at 314+4", find_ev(K_FALL, 300), 318);
    chk("R3 odd rise at 1-5 wrapped", find_ev(K_RISE_HS, 400), 621);
    chk("R9 v rises with line of vs rise", find_ev(K_V_RISE, 300), 310);
    chk("R10 field to 0 at 1+6", find_ev(K_FLD0, 1), 7);
    chk("R10 field to 1 at 314+6", find_ev(K_FLD1, 1), 320);
    chk("R2 first strobe entered line 1, wrap at 625", bl, NLINES);
    clear_ev();
    run_lines(NLINES);
    chk("R8 odd pulse across frame edge ends at 5", find_ev(K_FALL, 1), 5);
    chk("R2 second frame repeats even rise", find_ev(K_RISE_HS, 300), 310);
  endtask

  task automatic t_delay_sign();
    set_cfg(8'h03, 5'd10, 5'd6, 1'b0, 1'b0);
    run_lines(NLINES);
    clear_ev();
    run_lines(NLINES);
    chk("R4 odd rise at 1+3", find_ev(K_RISE_HS, 1), 4);
    chk("R8 odd fall at 1+10", find_ev(K_FALL, 1), 11);
    chk("R4 even rise at 314+3", find_ev(K_RISE_HS, 300), 317);
    chk("R8 even fall at 314+10", find_ev(K_FALL, 300), 324);
  endtask

  task automatic t_field_delays();
    set_cfg(8'h82, 5'd10, 5'd6, 1'b0, 1'b0);
    run_lines(NLINES);
    clear_ev();
    run_lines(NLINES);
    chk("R5 odd delay adds a line", find_ev(K_RISE_HS, 1), 4);
    chk("R5 odd delay leaves even", find_ev(K_RISE_HS, 300), 316);
    set_cfg(8'h42, 5'd10, 5'd6, 1'b0, 1'b0);
    run_lines(NLINES);
    clear_ev();
    run_lines(NLINES);
    chk("R6 even delay leaves odd", find_ev(K_RISE_HS, 1), 3);
    chk("R6 even delay adds a line", find_ev(K_RISE_HS, 300), 317);
  endtask

  task automatic t_half_adv();
    set_cfg(8'h03, 5'd10, 5'd6, 1'b1, 1'b0);
    run_lines(NLINES);
    clear_ev();
    run_lines(NLINES);
    chk("R7 odd rise on half strobe of line 3", find_ev(K_RISE_HALF, 1), 3);
    chk("R9 v waits for line 4 strobe", find_ev(K_V_RISE, 1), 4);
    chk("R7 even unaffected by odd advance", find_ev(K_RISE_HS, 300), 317);
    set_cfg(8'h03, 5'd10, 5'd6, 1'b0, 1'b1);
    run_lines(NLINES);
    clear_ev();
    run_lines(NLINES);
    chk("R7 even rise on half strobe of line 316", find_ev(K_RISE_HALF, 300), 316);
    chk("R7 odd unaffected by even advance", find_ev(K_RISE_HS, 1), 4);
    chk("R9 v never moves on half strobe", find_ev(K_V_HALF, 1), -1);
  endtask

  task automatic t_frame_sync();
    set_cfg(8'h03, 5'd10, 5'd6, 1'b0, 1'b0);
    run_lines(NLINES);
    run_lines(200);
    clear_ev();
    step_line(1'b1);
    run_lines(19);
    chk("R2 frame_sync restarts at line 1, rise at 4", find_ev(K_RISE_HS, 1), 4);
    chk("R2 frame_sync restarts at line 1, fall at 11", find_ev(K_FALL, 1), 11);
    run_lines(NLINES - 20);
  endtask

  // vsync end and field edge on the same strobe
  task automatic t_coincide();
    set_cfg(8'h03, 5'd8, 5'd8, 1'b0, 1'b0);
    run_lines(NLINES);
    clear_ev();
    run_lines(NLINES);
    chk("R8 fall at 9 while field edge also due", find_ev(K_FALL, 1), 9);
    chk("R10 field to 0 at 9 beside vs fall", find_ev(K_FLD0, 1), 9);
    chk("R10 field to 1 at 322", find_ev(K_FLD1, 1), 322);
  endtask

  task automatic t_frame_capture();
    set_cfg(8'h03, 5'd10, 5'd6, 1'b0, 1'b0);
    run_lines(NLINES);
    clear_ev();
    run_lines(100);
    set_cfg(8'h06, 5'd10, 5'd6, 1'b0, 1'b0);
    run_lines(NLINES - 100);
    chk("R11 mid-frame change ignored for even rise", find_ev(K_RISE_HS, 300), 317);
    clear_ev();
    run_lines(NLINES);
    chk("R11 new offset applies to odd next frame", find_ev(K_RISE_HS, 1), 7);
    chk("R11 new offset applies to even next frame", find_ev(K_RISE_HS, 300), 320);
  endtask

  task automatic t_end_latch();
    set_cfg(8'h65, 5'd4, 5'd6, 1'b0, 1'b0);
    run_lines(NLINES);
    set_cfg(8'h65, 5'd12, 5'd6, 1'b0, 1'b0);
    clear_ev();
    run_lines(NLINES);
    chk("R12 pulse risen at 621 keeps end 5", find_ev(K_FALL, 1), 5);
    chk("R12 even pulse uses new end 326", find_ev(K_FALL, 300), 326);
    clear_ev();
    run_lines(20);
    chk("R12 next odd pulse ends at 13", find_ev(K_FALL, 1), 13);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    hs_strobe = 1'b0; half_strobe = 1'b0; frame_sync = 1'b0;
    set_cfg(8'h65, 5'd4, 5'd6, 1'b0, 1'b0);
    bl = NLINES;
    ev_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pv = vs_out; pvf = v_flag; pf = field_out;
    t_reset();
    t_defaults();
    t_delay_sign();
    t_field_delays();
    t_half_adv();
    t_frame_sync();
    t_coincide();
    t_frame_capture();
    t_end_latch();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule